// File: doc/BRIEF.md
# Cascadable Priority Encoder

This block resolves a set of service requests into the binary index of the most urgent one. A higher request number always wins: a request counts only when nothing above it is active. The design is purely combinational. It is built from identical eight-lane stages that are linked through an enable chain. The default configuration joins two such stages into a 16-request encoder.

Each stage accepts an enable from the stage above it and passes an enable to the stage below it. A lower stage is enabled only when every stage above it has no request. The stage that holds the winning request raises its group flag. That flag gives the upper bits of the index, and the lane code of that stage gives the lower bits. The whole encoder has its own enable input. It also has a group flag, which says that some request won, and an enable output, which lets a further chain of lower priority continue below it. A parameter chooses how each stage resolves priority: as a linear scan, or as a one-hot winner mask that is folded into the code bits.

Top module: `prio_chain`

## Requirements
- R1: With en_i at 1 and at least one request active, code_o equals the index of the highest-numbered bit set in req_i (bit 15 has the highest priority in the default 16-request configuration).
- R2: grp_o is 1 exactly when en_i is 1 and at least one bit of req_i is 1.
- R3: en_o is 1 exactly when en_i is 1 and no bit of req_i is 1, so grp_o and en_o are never 1 together.
- R4: With en_i at 0, code_o is 0, grp_o is 0 and en_o is 0, whatever the pattern on req_i.
- R5: With en_i at 1 and req_i all zero (idle), code_o is 0 and grp_o is 0.
- R6: The most significant bit of code_o is 1 exactly when the winning request lies in the upper half of req_i, that is, when the upper stage reports a request.
- R7: Requests below the winning one have no effect: setting or clearing any bit under the highest set bit leaves code_o unchanged.
- R8: The scan variant (STYLE 0) and the one-hot mask variant (STYLE 1) give identical code_o, grp_o and en_o for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en_i | input | 1 | Enables the whole encoder; feeds the highest stage |
| req_i | input | LANE_W*STAGES (16) | Request lines; a higher index has a higher priority |
| code_o | output | $clog2(LANE_W*STAGES) (4) | Index of the winning request; 0 when idle or disabled |
| grp_o | output | 1 | A request won while enabled |
| en_o | output | 1 | Enable for a lower-priority chain; enabled and idle |

## Verification
On every input change the assertions check the following. The winning bit is really set in req_i, and no bit above it is set. The group flag and the enable output are never 1 together, and each one follows the enable and the request lines. A disabled encoder drives every output to zero. Two things only the bench can show. The first is that the full index is exact for each of the 65,536 request patterns, including the cases where the upper stage hands over to the lower one. The second is that the two resolution variants agree on every pattern.

// File: rtl/prio_pkg.sv
package prio_pkg;

   // Resolution styles for one stage
   localparam int STYLE_SCAN = 0;   // linear scan, last hit wins
   localparam int STYLE_MASK = 1;   // one-hot winner, folded into code bits

   function automatic bit is_pow2(input int v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/prio_stage.sv
module prio_stage #(
   parameter int LANE_W = 8,
   parameter int STYLE  = prio_pkg::STYLE_SCAN
) (
   input  logic                      ei,
   input  logic [LANE_W-1:0]         req,
   output logic [$clog2(LANE_W)-1:0] code,
   output logic                      gs,
   output logic                      eo
);
   localparam int LANE_CW = $clog2(LANE_W);

   logic [LANE_CW-1:0] raw;
   logic               any_req;

   if (!prio_pkg::is_pow2(LANE_W)) begin : g_bad_lane
      $error("prio_stage: LANE_W must be a power of two, at least 2");
   end
   if (STYLE != prio_pkg::STYLE_SCAN && STYLE != prio_pkg::STYLE_MASK) begin : g_bad_style
      $error("prio_stage: unknown STYLE");
   end

   assign any_req = |req;

   if (STYLE == prio_pkg::STYLE_SCAN) begin : g_scan
      always_comb begin
         raw = '0;
         for (int i = 0; i < LANE_W; i++) begin
            if (req[i]) raw = LANE_CW'(i);
         end
      end
   end else begin : g_mask
      logic [LANE_W-1:0] hot;
      for (genvar i = 0; i < LANE_W; i++) begin : g_hot
         if (i == LANE_W - 1) begin : g_top
            assign hot[i] = req[i];
         end else begin : g_low
            assign hot[i] = req[i] & ~(|req[LANE_W-1:i+1]);
         end
      end
      always_comb begin
         raw = '0;
         for (int b = 0; b < LANE_CW; b++) begin
            for (int i = 0; i < LANE_W; i++) begin
               if (((i >> b) & 1) == 1) raw[b] = raw[b] | hot[i];
            end
         end
      end
   end

   assign code = ei ? raw : '0;
   assign gs   = ei & any_req;
   assign eo   = ei & ~any_req;

endmodule

// File: rtl/prio_chain.sv
module prio_chain #(
   parameter int LANE_W = 8,
   parameter int STAGES = 2,
   parameter int STYLE  = prio_pkg::STYLE_SCAN
) (
   input  logic                              en_i,
   input  logic [LANE_W*STAGES-1:0]          req_i,
   output logic [$clog2(LANE_W*STAGES)-1:0]  code_o,
   output logic                              grp_o,
   output logic                              en_o
);
   localparam int REQ_W   = LANE_W * STAGES;
   localparam int CODE_W  = $clog2(REQ_W);
   localparam int LANE_CW = $clog2(LANE_W);
   localparam int SEL_W   = CODE_W - LANE_CW;

   if (!prio_pkg::is_pow2(STAGES)) begin : g_bad_stages
      $error("prio_chain: STAGES must be a power of two, at least 2");
   end

   logic [STAGES-1:0]  st_ei;
   logic [STAGES-1:0]  st_eo;
   logic [STAGES-1:0]  st_gs;
   logic [LANE_CW-1:0] st_code [STAGES];
   logic [LANE_CW-1:0] low_code;
   logic [SEL_W-1:0]   sel_code;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == STAGES - 1) begin : g_head
         assign st_ei[s] = en_i;
      end else begin : g_link
         assign st_ei[s] = st_eo[s+1];
      end

      prio_stage #(
         .LANE_W (LANE_W),
         .STYLE  (STYLE)
      ) u_stage (
         .ei   (st_ei[s]),
         .req  (req_i[s*LANE_W +: LANE_W]),
         .code (st_code[s]),
         .gs   (st_gs[s]),
         .eo   (st_eo[s])
      );
   end

   always_comb begin
      low_code = '0;
      sel_code = '0;
      for (int s = 0; s < STAGES; s++) begin
         low_code = low_code | st_code[s];
         if (st_gs[s]) sel_code = sel_code | SEL_W'(s);
      end
   end

   assign code_o = {sel_code, low_code};
   assign grp_o  = |st_gs;
   assign en_o   = st_eo[0];

endmodule

// File: rtl/prio_chain_chk.sv
module prio_chain_chk #(
   parameter int REQ_W  = 16,
   parameter int CODE_W = 4
) (
   input logic              en_i,
   input logic [REQ_W-1:0]  req_i,
   input logic [CODE_W-1:0] code_o,
   input logic              grp_o,
   input logic              en_o
);
   always_comb begin
      // R1: the reported winner is an active request
      if (grp_o) a_r1_winner_active: assert (req_i[code_o] == 1'b1);
      // R7: nothing above the winner is active
      if (grp_o) a_r7_nothing_above: assert ((req_i >> code_o) == REQ_W'(1));
      // R2: group flag needs enable and a request
      a_r2_group_flag: assert (grp_o == (en_i && (req_i != '0)));
      // R3: group flag and enable output are exclusive; en_o follows idle
      a_r3_exclusive: assert (!(grp_o && en_o));
      a_r3_pass_on: assert (en_o == (en_i && (req_i == '0)));
      // R4: disabled encoder is silent
      if (!en_i) a_r4_disabled: assert (code_o == '0 && !grp_o && !en_o);
      // R5: idle gives a zero code
      if (req_i == '0) a_r5_idle_zero: assert (code_o == '0);
   end
endmodule

bind prio_chain prio_chain_chk #(.REQ_W(REQ_W), .CODE_W(CODE_W)) u_prio_chain_chk (
   .en_i   (en_i),
   .req_i  (req_i),
   .code_o (code_o),
   .grp_o  (grp_o),
   .en_o   (en_o)
);

// File: tb/test_prio_chain.sv
module test_prio_chain;
   localparam int LANE_W = 8;
   localparam int STAGES = 2;
   localparam int REQ_W  = LANE_W * STAGES;
   localparam int CODE_W = $clog2(REQ_W);

   logic              clk = 1'b0;
   logic              en;
   logic [REQ_W-1:0]  req;
   logic [CODE_W-1:0] code_a, code_b;
   logic              grp_a, grp_b, eo_a, eo_b;

   int  checks   = 0;
   int  failures = 0;
   bit  done     = 0;

   always #10 clk = ~clk;   // 50 MHz

   prio_chain #(.LANE_W(LANE_W), .STAGES(STAGES), .STYLE(0)) i_prio_chain (
      .en_i(en), .req_i(req), .code_o(code_a), .grp_o(grp_a), .en_o(eo_a));

   prio_chain #(.LANE_W(LANE_W), .STAGES(STAGES), .STYLE(1)) i_prio_chain_mask (
      .en_i(en), .req_i(req), .code_o(code_b), .grp_o(grp_b), .en_o(eo_b));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s req=%h en=%0d actual=%0d expected=%0d", tag, req, en, act, exp);
      end
   endtask

   function automatic int top_bit(input logic [REQ_W-1:0] v);
      int r = 0;
      for (int i = 0; i < REQ_W; i++) if (v[i]) r = i;
      return r;
   endfunction

   task automatic apply_and_check(input logic e, input logic [REQ_W-1:0] r);
      int  exp_code;
      bit  exp_grp, exp_eo;
      @(posedge clk);
      en  = e;
      req = r;
      @(negedge clk);
      exp_grp  = e && (r != 0);
      exp_eo   = e && (r == 0);
      exp_code = exp_grp ? top_bit(r) : 0;
      if (!e) begin
         check(code_a == 0 && !grp_a && !eo_a, "R4", {code_a, grp_a, eo_a}, 0);
      end else if (r == 0) begin
         check(code_a == 0 && !grp_a, "R5", int'(code_a), 0);
      end else begin
         check(int'(code_a) == exp_code, "R1", int'(code_a), exp_code);
         check(code_a[CODE_W-1] == (exp_code >= LANE_W), "R6",
               int'(code_a[CODE_W-1]), int'(exp_code >= LANE_W));
      end
      check(grp_a == exp_grp, "R2", int'(grp_a), int'(exp_grp));
      check(eo_a == exp_eo, "R3", int'(eo_a), int'(exp_eo));
      check(code_b == code_a && grp_b == grp_a && eo_b == eo_a, "R8",
            {code_b, grp_b, eo_b}, {code_a, grp_a, eo_a});
   endtask

   // Watchdog
   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      en  = 1'b0;
      req = '0;
      // Initial quiet state: disabled, no requests
      @(negedge clk);
      check(code_a == 0 && !grp_a && !eo_a, "R4 initial", {code_a, grp_a, eo_a}, 0);

      // R1/R2/R3/R5/R6/R8: every request pattern, enabled
      for (int p = 0; p < (1 << REQ_W); p++) apply_and_check(1'b1, REQ_W'(p));

      // R4: disabled, each stage's full byte range plus mixed patterns
      for (int p = 0; p < 256; p++) begin
         apply_and_check(1'b0, REQ_W'(p));
         apply_and_check(1'b0, REQ_W'(p << LANE_W));
         apply_and_check(1'b0, REQ_W'(p * 257));
      end

      // R7: toggling bits below the winner leaves the code unchanged
      for (int w = 1; w < REQ_W; w++) begin
         for (int k = 0; k < 8; k++) begin
            logic [REQ_W-1:0] below;
            below = REQ_W'((k * 16'h9e37 + w * 16'h3b1) & ((1 << w) - 1));
            @(posedge clk);
            en  = 1'b1;
            req = REQ_W'(1 << w) | below;
            @(negedge clk);
            check(int'(code_a) == w, "R7", int'(code_a), w);
         end
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule